// File: doc/BRIEF.md
# Memory Dependence Scheduling Unit

This block holds the in-flight memory operations of an out-of-order core (loads, stores, atomics and the two kinds of barrier) and decides when each may go to the issue queue. Each entry keeps a sequence number, a thread number, its operation kind, and two readiness flags. One flag says that the register operands are available. The other says that memory ordering allows the operation to go. An entry may also carry the sequence number of a producer it waits on. An operation goes to the issue-ready stream only when both flags are set, so whichever flag arrives last releases it.

The producer of a newly inserted operation is chosen in this order. A load or atomic takes the active load-barrier number. Failing that, a store or atomic takes the active store-barrier number. Otherwise it takes the tag from the external dependence predictor, where zero means no producer. A producer tag that names no live entry leaves the operation free to go at once. When a store, atomic or barrier completes, its waiters are woken. Completion also frees the entry, and a squash removes a thread's younger entries.

Both valid/ready interfaces follow the usual stream rules. An insert is accepted on a cycle with `ins_valid` and `ins_ready` both high, and `ins_ready` is low exactly while every entry is in use. On the output, `rdy_valid` stays high until `rdy_ready` takes the operation. It can drop only through a squash, a reschedule or a completion. An older operation that becomes ready during a stall may take the head of the stream. All other pins are single-cycle command strobes.

Top module: `memdep_sched`

## Requirements
- R1: A normal insert (kind code 0 load, 1 store, 2 atomic) whose producer is zero, or names no live entry, is memory-ready at once. If `ins_regs_ok` is high it appears on the ready stream in the cycle after acceptance.
- R2: An operation that waits on a live producer is not forwarded when its registers become ready. A register-ready strobe releases an operation that is already memory-ready.
- R3: Completing a store or atomic wakes its waiters. A waiter with registers ready is forwarded, and one without only becomes memory-ready. Completing a load wakes nothing.
- R4: A full barrier (kind 3) makes later loads, stores and atomics wait on it. A write barrier (kind 4) makes only stores and atomics wait. Barrier entries are never forwarded themselves.
- R5: Reset clears both barrier flags. Completing a barrier clears a flag only when the flag's recorded number equals the completing barrier's number.
- R6: A non-speculative insert (`ins_nonspec`) is not forwarded until a `go_en` strobe for its sequence number arrives. A register-ready strobe alone does not release it.
- R7: A reschedule strobe withdraws a forwarded operation into a replay set. A replay strobe returns every member of the set to the ready stream.
- R8: A squash removes the entries of `squash_tid` whose sequence numbers exceed `squash_seq`, including members of the replay set. It clears any barrier flag recorded for a removed barrier and leaves other threads untouched.
- R9: Among ready operations the smallest sequence number is presented first. While `rdy_ready` is low the presented operation stays valid.
- R10: `full` and `empty` reflect table occupancy. An insert presented while full is refused and leaves no trace.
- R11: A completion strobe frees the entry with that sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert can be accepted (a free entry exists) |
| ins_kind | input | 3 | 0 load, 1 store, 2 atomic, 3 full barrier, 4 write barrier |
| ins_nonspec | input | 1 | Insert as non-speculative |
| ins_seq | input | SEQ_W | Sequence number of the inserted operation |
| ins_tid | input | TID_W | Thread of the inserted operation |
| ins_regs_ok | input | 1 | Register operands already available |
| pred_tag | input | SEQ_W | Producer tag from the dependence predictor, 0 for none |
| regs_en | input | 1 | Register-ready strobe |
| regs_seq | input | SEQ_W | Target of the register-ready strobe |
| go_en | input | 1 | Explicit release of a non-speculative operation |
| go_seq | input | SEQ_W | Target of the release |
| cmp_en | input | 1 | Completion strobe |
| cmp_seq | input | SEQ_W | Completing sequence number |
| resched_en | input | 1 | Reschedule strobe |
| resched_seq | input | SEQ_W | Operation to reschedule |
| replay_en | input | 1 | Release the whole replay set |
| squash_en | input | 1 | Squash strobe |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| squash_tid | input | TID_W | Thread being squashed |
| rdy_valid | output | 1 | An operation is ready for issue |
| rdy_ready | input | 1 | Issue queue accepts the operation |
| rdy_seq | output | SEQ_W | Sequence number of the presented operation |
| rdy_tid | output | TID_W | Thread of the presented operation |
| full | output | 1 | Every entry in use |
| empty | output | 1 | No entry in use |

## Verification
The bench builds the block with four entries and two threads, so the table fills after four inserts and the refusal of a fifth can be seen at the ports. Two threads let a squash of one thread run next to a replay-set member of the other. Sixteen-bit sequence numbers leave room for predictor tags that name retired or absent operations. They also leave room for barriers overwriting one another's recorded number.

// File: rtl/memdep_pkg.sv
package memdep_pkg;
  typedef enum logic [2:0] {
    K_LOAD   = 3'd0,
    K_STORE  = 3'd1,
    K_ATOMIC = 3'd2,
    K_MEMBAR = 3'd3,
    K_WRBAR  = 3'd4
  } op_kind_e;
endpackage

// File: rtl/memdep_fence.sv
module memdep_fence #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_full,
  input  logic             set_write,
  input  logic [SEQ_W-1:0] set_seq,
  input  logic             done_en,
  input  logic [SEQ_W-1:0] done_seq,
  input  logic             kill_ld,
  input  logic             kill_st,
  output logic             ld_on,
  output logic [SEQ_W-1:0] ld_sn,
  output logic             st_on,
  output logic [SEQ_W-1:0] st_sn
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_on <= 1'b0;
      st_on <= 1'b0;
      ld_sn <= '0;
      st_sn <= '0;
    end else begin
      if ((done_en && ld_sn == done_seq) || kill_ld) ld_on <= 1'b0;
      if ((done_en && st_sn == done_seq) || kill_st) st_on <= 1'b0;
      if (set_full) begin
        ld_on <= 1'b1;
        ld_sn <= set_seq;
      end
      if (set_write) begin
        st_on <= 1'b1;
        st_sn <= set_seq;
      end
    end
  end

  // R4
  fence_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_full |=> (ld_on && st_on && ld_sn == st_sn));

  // R5
  ld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_on) |-> $past(done_en || kill_ld));
endmodule

// File: rtl/memdep_slot.sv
module memdep_slot #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     used,
  output logic [IDX_W-1:0] free_idx,
  output logic             has_free
);
  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/memdep_oldest.sv
module memdep_oldest #(
  parameter int N     = 16,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic [SEQ_W-1:0] seq_i [N],
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    gnt  = '0;
    idx  = '0;
    any  = 1'b0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!any || seq_i[i] < best)) begin
        any  = 1'b1;
        best = seq_i[i];
        idx  = IDX_W'(i);
      end
    end
    if (any) gnt[idx] = 1'b1;
  end

  // R9
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  // R9
  grant_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> any);
endmodule

// File: rtl/memdep_sched.sv
module memdep_sched
  import memdep_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int SEQ_W   = 16,
  parameter int THREADS = 2,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [2:0]       ins_kind,
  input  logic             ins_nonspec,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [TID_W-1:0] ins_tid,
  input  logic             ins_regs_ok,
  input  logic [SEQ_W-1:0] pred_tag,
  input  logic             regs_en,
  input  logic [SEQ_W-1:0] regs_seq,
  input  logic             go_en,
  input  logic [SEQ_W-1:0] go_seq,
  input  logic             cmp_en,
  input  logic [SEQ_W-1:0] cmp_seq,
  input  logic             resched_en,
  input  logic [SEQ_W-1:0] resched_seq,
  input  logic             replay_en,
  input  logic             squash_en,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic [TID_W-1:0] squash_tid,
  output logic             rdy_valid,
  input  logic             rdy_ready,
  output logic [SEQ_W-1:0] rdy_seq,
  output logic [TID_W-1:0] rdy_tid,
  output logic             full,
  output logic             empty
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] v_q, regs_q, mem_q, sent_q, rpl_q, hasp_q;
  logic [SEQ_W-1:0] seq_q  [DEPTH];
  logic [SEQ_W-1:0] prod_q [DEPTH];
  logic [TID_W-1:0] tid_q  [DEPTH];
  logic [2:0]       kind_q [DEPTH];

  logic [DEPTH-1:0] pend, cmp_hit, sq_kill, gnt;
  logic [IDX_W-1:0] slot, pick;
  logic             has_free, ins_fire, rdy_fire;
  logic             ld_on, st_on, kill_ld, kill_st;
  logic [SEQ_W-1:0] ld_sn, st_sn, prod_sel;
  logic             cmp_bar, cmp_wakes, prod_live;
  logic             ins_is_bar, ins_lda, ins_sta;

  assign ins_is_bar = (ins_kind == K_MEMBAR) || (ins_kind == K_WRBAR);
  assign ins_lda    = (ins_kind == K_LOAD)   || (ins_kind == K_ATOMIC);
  assign ins_sta    = (ins_kind == K_STORE)  || (ins_kind == K_ATOMIC);
  assign ins_ready  = has_free;
  assign ins_fire   = ins_valid && has_free;
  assign rdy_fire   = rdy_valid && rdy_ready;
  assign full       = &v_q;
  assign empty      = ~|v_q;

  // Producer choice: load barrier, then store barrier, then predictor.
  always_comb begin
    if (ins_lda && ld_on)      prod_sel = ld_sn;
    else if (ins_sta && st_on) prod_sel = st_sn;
    else                       prod_sel = pred_tag;
  end

  always_comb begin
    cmp_bar   = 1'b0;
    cmp_wakes = 1'b0;
    kill_ld   = 1'b0;
    kill_st   = 1'b0;
    prod_live = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      cmp_hit[i] = cmp_en && v_q[i] && seq_q[i] == cmp_seq;
      sq_kill[i] = squash_en && v_q[i] && tid_q[i] == squash_tid &&
                   seq_q[i] > squash_seq;
      pend[i]    = v_q[i] && regs_q[i] && mem_q[i] && !sent_q[i] && !rpl_q[i];
      if (cmp_hit[i]) begin
        if (kind_q[i] == K_MEMBAR || kind_q[i] == K_WRBAR) cmp_bar = 1'b1;
        if (kind_q[i] != K_LOAD) cmp_wakes = 1'b1;
      end
      if (sq_kill[i] && seq_q[i] == ld_sn) kill_ld = 1'b1;
      if (sq_kill[i] && seq_q[i] == st_sn) kill_st = 1'b1;
      if (v_q[i] && !cmp_hit[i] && !sq_kill[i] && seq_q[i] == prod_sel)
        prod_live = 1'b1;
    end
    if (prod_sel == '0) prod_live = 1'b0;
  end

  memdep_slot #(.N(DEPTH), .IDX_W(IDX_W)) u_slot (
    .used(v_q), .free_idx(slot), .has_free(has_free)
  );

  memdep_oldest #(.N(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(pend), .seq_i(seq_q),
    .gnt(gnt), .idx(pick), .any(rdy_valid)
  );

  memdep_fence #(.SEQ_W(SEQ_W)) u_fence (
    .clk(clk), .rst_n(rst_n),
    .set_full(ins_fire && ins_kind == K_MEMBAR),
    .set_write(ins_fire && ins_is_bar),
    .set_seq(ins_seq),
    .done_en(cmp_bar), .done_seq(cmp_seq),
    .kill_ld(kill_ld), .kill_st(kill_st),
    .ld_on(ld_on), .ld_sn(ld_sn), .st_on(st_on), .st_sn(st_sn)
  );

  assign rdy_seq = seq_q[pick];
  assign rdy_tid = tid_q[pick];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= '0;
      regs_q <= '0;
      mem_q  <= '0;
      sent_q <= '0;
      rpl_q  <= '0;
      hasp_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        seq_q[i]  <= '0;
        prod_q[i] <= '0;
        tid_q[i]  <= '0;
        kind_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (v_q[i]) begin
          if (regs_en && seq_q[i] == regs_seq) regs_q[i] <= 1'b1;
          if (go_en && seq_q[i] == go_seq) begin
            regs_q[i] <= 1'b1;
            mem_q[i]  <= 1'b1;
          end
          if (cmp_wakes && hasp_q[i] && prod_q[i] == cmp_seq) begin
            mem_q[i]  <= 1'b1;
            hasp_q[i] <= 1'b0;
          end
          if (rdy_fire && gnt[i]) sent_q[i] <= 1'b1;
          if (replay_en) rpl_q[i] <= 1'b0;
          if (resched_en && seq_q[i] == resched_seq) begin
            sent_q[i] <= 1'b0;
            rpl_q[i]  <= 1'b1;
          end
          if (cmp_hit[i] || sq_kill[i]) v_q[i] <= 1'b0;
        end
        if (ins_fire && slot == IDX_W'(i)) begin
          v_q[i]    <= 1'b1;
          seq_q[i]  <= ins_seq;
          tid_q[i]  <= ins_tid;
          kind_q[i] <= ins_kind;
          rpl_q[i]  <= 1'b0;
          prod_q[i] <= prod_sel;
          if (ins_is_bar) begin
            regs_q[i] <= 1'b1;
            mem_q[i]  <= 1'b1;
            sent_q[i] <= 1'b1;
            hasp_q[i] <= 1'b0;
          end else if (ins_nonspec) begin
            regs_q[i] <= 1'b0;
            mem_q[i]  <= 1'b0;
            sent_q[i] <= 1'b0;
            hasp_q[i] <= 1'b0;
          end else begin
            regs_q[i] <= ins_regs_ok;
            mem_q[i]  <= !prod_live;
            sent_q[i] <= 1'b0;
            hasp_q[i] <= prod_live;
          end
        end
      end
    end
  end

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_valid && !rdy_ready && !squash_en && !resched_en && !cmp_en)
      |=> rdy_valid);

  // R10
  free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |-> !v_q[slot]);

  // R10
  refuse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !cmp_en && !squash_en) |=> full);

  // R6
  nonspec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && ins_nonspec && !ins_is_bar)
      |=> !(rdy_valid && rdy_seq == $past(ins_seq)));
endmodule

// File: tb/sim_memdep_sched.sv
module sim_memdep_sched;
  localparam int DEPTH = 4;
  localparam int SEQ_W = 16;
  localparam int THREADS = 2;
  localparam int TID_W = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 0, ins_nonspec = 0, ins_regs_ok = 0;
  logic [2:0] ins_kind = '0;
  logic [SEQ_W-1:0] ins_seq = '0, pred_tag = '0;
  logic [TID_W-1:0] ins_tid = '0, squash_tid = '0;
  logic regs_en = 0, go_en = 0, cmp_en = 0, resched_en = 0, replay_en = 0;
  logic squash_en = 0, rdy_ready = 0;
  logic [SEQ_W-1:0] regs_seq = '0, go_seq = '0, cmp_seq = '0, resched_seq = '0;
  logic [SEQ_W-1:0] squash_seq = '0;
  logic ins_ready, rdy_valid, full, empty;
  logic [SEQ_W-1:0] rdy_seq;
  logic [TID_W-1:0] rdy_tid;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  memdep_sched #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .THREADS(THREADS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_kind(ins_kind),
    .ins_nonspec(ins_nonspec), .ins_seq(ins_seq), .ins_tid(ins_tid),
    .ins_regs_ok(ins_regs_ok), .pred_tag(pred_tag),
    .regs_en(regs_en), .regs_seq(regs_seq), .go_en(go_en), .go_seq(go_seq),
    .cmp_en(cmp_en), .cmp_seq(cmp_seq),
    .resched_en(resched_en), .resched_seq(resched_seq), .replay_en(replay_en),
    .squash_en(squash_en), .squash_seq(squash_seq), .squash_tid(squash_tid),
    .rdy_valid(rdy_valid), .rdy_ready(rdy_ready), .rdy_seq(rdy_seq),
    .rdy_tid(rdy_tid), .full(full), .empty(empty)
  );

  // {regs_ok, pred_tag, seq}: loads on thread 0, one per row
  localparam logic [32:0] VEC [6] = '{
    {1'b1, 16'd0,   16'd1},
    {1'b1, 16'd999, 16'd2},
    {1'b0, 16'd0,   16'd3},
    {1'b1, 16'd1,   16'd4},
    {1'b0, 16'd500, 16'd5},
    {1'b1, 16'd0,   16'd6}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_ins(input int kind, input int seq, input int tid,
                       input bit regs, input int tag, input bit ns);
    ins_valid = 1; ins_kind = 3'(kind); ins_seq = 16'(seq); ins_tid = 1'(tid);
    ins_regs_ok = regs; pred_tag = 16'(tag); ins_nonspec = ns;
    step();
    ins_valid = 0; ins_nonspec = 0; ins_regs_ok = 0;
  endtask

  task automatic t_regs(input int seq);
    regs_en = 1; regs_seq = 16'(seq); step(); regs_en = 0;
  endtask

  task automatic t_go(input int seq);
    go_en = 1; go_seq = 16'(seq); step(); go_en = 0;
  endtask

  task automatic t_cmp(input int seq);
    cmp_en = 1; cmp_seq = 16'(seq); step(); cmp_en = 0;
  endtask

  task automatic t_resched(input int seq);
    resched_en = 1; resched_seq = 16'(seq); step(); resched_en = 0;
  endtask

  task automatic t_replay();
    replay_en = 1; step(); replay_en = 0;
  endtask

  task automatic t_squash(input int tid, input int seq);
    squash_en = 1; squash_tid = 1'(tid); squash_seq = 16'(seq); step();
    squash_en = 0;
  endtask

  task automatic t_take();
    rdy_ready = 1; step(); rdy_ready = 0;
  endtask

  // expect a presented operation, then accept it
  task automatic expect_take(input string req, input int seq);
    chk(req, int'(rdy_valid), 1);
    chk(req, int'(rdy_seq), seq);
    t_take();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    step();
    // R10 R5 reset state
    chk("R10 reset empty", int'(empty), 1);
    chk("R10 reset full", int'(full), 0);
    chk("R10 reset ins_ready", int'(ins_ready), 1);
    chk("R9 reset rdy_valid", int'(rdy_valid), 0);

    // R1 table walk
    foreach (VEC[k]) begin
      t_ins(0, int'(VEC[k][15:0]), 0, VEC[k][32], int'(VEC[k][31:16]), 0);
      if (!VEC[k][32]) begin
        chk("R2 wait regs", int'(rdy_valid), 0);
        t_regs(int'(VEC[k][15:0]));
      end
      expect_take("R1 table", int'(VEC[k][15:0]));
      chk("R1 table drained", int'(rdy_valid), 0);
      t_cmp(int'(VEC[k][15:0]));
      chk("R11 freed", int'(empty), 1);
    end

    // R2 R3 store wakes a waiting load
    t_ins(1, 10, 0, 1, 0, 0);
    expect_take("R1 store", 10);
    t_ins(0, 11, 0, 0, 10, 0);
    t_regs(11);
    chk("R2 producer live", int'(rdy_valid), 0);
    t_cmp(10);
    expect_take("R3 wake ready", 11);
    t_cmp(11);

    // R3 woken without registers only becomes memory-ready
    t_ins(2, 20, 0, 1, 0, 0);
    expect_take("R1 atomic", 20);
    t_ins(0, 21, 0, 0, 20, 0);
    t_cmp(20);
    chk("R3 woken no regs", int'(rdy_valid), 0);
    t_regs(21);
    expect_take("R3 regs after wake", 21);
    t_cmp(21);

    // R3 load completion wakes nothing; R8 squash clears the waiter
    t_ins(0, 30, 0, 1, 0, 0);
    expect_take("R1 load", 30);
    t_ins(0, 31, 0, 1, 30, 0);
    t_cmp(30);
    chk("R3 load wakes none", int'(rdy_valid), 0);
    t_squash(0, 30);
    chk("R8 squash removes", int'(empty), 1);

    // R4 full barrier holds loads and stores; R9 oldest and hold
    t_ins(3, 40, 0, 1, 0, 0);
    chk("R4 barrier not forwarded", int'(rdy_valid), 0);
    t_ins(0, 41, 0, 1, 0, 0);
    t_ins(1, 42, 0, 1, 0, 0);
    chk("R4 held by barrier", int'(rdy_valid), 0);
    t_cmp(40);
    chk("R9 oldest first", int'(rdy_seq), 41);
    step();
    chk("R9 hold valid", int'(rdy_valid), 1);
    chk("R9 hold seq", int'(rdy_seq), 41);
    t_take();
    expect_take("R9 next", 42);
    t_cmp(41);
    t_cmp(42);
    t_ins(0, 43, 0, 1, 0, 0);
    expect_take("R5 flag cleared", 43);
    t_cmp(43);

    // R4 write barrier holds stores only
    t_ins(4, 50, 0, 1, 0, 0);
    t_ins(0, 51, 0, 1, 0, 0);
    expect_take("R4 load passes write barrier", 51);
    t_ins(1, 52, 0, 1, 0, 0);
    chk("R4 store held", int'(rdy_valid), 0);
    t_cmp(50);
    expect_take("R4 store released", 52);
    t_cmp(51);
    t_cmp(52);

    // R9 oldest by sequence number, not by slot
    t_ins(4, 140, 0, 1, 0, 0);
    t_ins(1, 145, 0, 1, 0, 0);
    t_ins(1, 143, 0, 1, 0, 0);
    t_cmp(140);
    expect_take("R9 smaller seq first", 143);
    expect_take("R9 then larger", 145);
    t_cmp(143);
    t_cmp(145);

    // R5 only the matching barrier clears the flag
    t_ins(3, 60, 0, 1, 0, 0);
    t_ins(3, 61, 0, 1, 0, 0);
    t_cmp(60);
    t_ins(0, 62, 0, 1, 0, 0);
    chk("R5 stale number no clear", int'(rdy_valid), 0);
    t_cmp(61);
    expect_take("R5 matching clear", 62);
    t_cmp(62);

    // R8 squashed barrier releases its flags
    t_ins(3, 70, 0, 1, 0, 0);
    t_squash(0, 69);
    t_ins(0, 71, 0, 1, 0, 0);
    expect_take("R8 barrier squashed", 71);
    t_cmp(71);

    // R6 non-speculative
    t_ins(1, 80, 0, 1, 0, 1);
    chk("R6 nonspec held", int'(rdy_valid), 0);
    t_regs(80);
    chk("R6 regs not enough", int'(rdy_valid), 0);
    t_go(80);
    expect_take("R6 released by go", 80);
    t_cmp(80);

    // R7 reschedule and replay
    t_ins(0, 90, 0, 1, 0, 0);
    t_ins(0, 91, 0, 1, 0, 0);
    t_take();
    t_resched(90);
    chk("R7 rescheduled withheld", int'(rdy_seq), 91);
    t_take();
    t_resched(91);
    chk("R7 replay set idle", int'(rdy_valid), 0);
    t_replay();
    expect_take("R7 replay first", 90);
    expect_take("R7 replay second", 91);
    t_cmp(90);
    t_cmp(91);

    // R8 squash prunes replay set of one thread only
    t_ins(0, 100, 1, 1, 0, 0);
    t_take();
    t_resched(100);
    t_ins(0, 101, 0, 1, 0, 0);
    t_take();
    t_resched(101);
    t_squash(0, 99);
    t_replay();
    chk("R8 other thread kept", int'(rdy_tid), 1);
    expect_take("R8 other thread kept", 100);
    chk("R8 squashed replay gone", int'(rdy_valid), 0);
    t_cmp(100);
    chk("R8 empty after", int'(empty), 1);

    // R10 full and refusal
    for (int s = 110; s < 114; s++) t_ins(0, s, 0, 0, 0, 0);
    chk("R10 full", int'(full), 1);
    chk("R10 ins_ready low", int'(ins_ready), 0);
    chk("R10 not empty", int'(empty), 0);
    t_ins(0, 114, 0, 1, 0, 0);
    chk("R10 refused not visible", int'(rdy_valid), 0);
    for (int s = 110; s < 115; s++) t_regs(s);
    for (int s = 110; s < 114; s++) expect_take("R10 drain", s);
    chk("R10 refused never appears", int'(rdy_valid), 0);
    for (int s = 110; s < 114; s++) t_cmp(s);
    chk("R11 all freed", int'(empty), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule